// File: doc/BRIEF.md
# Integer Execution Unit with Extended Opcode Map

This block is the integer execution stage of a 32-bit CPU with sixteen general registers. Each cycle in which `in_valid` is high, it takes a 5-bit major opcode and two operands, A (the current destination value or first source) and B (the second source, already resolved to a register or an immediate). One clock later it presents the 32-bit result, four condition flags and a matching `out_valid`.

The supported operations are addition, subtraction, AND, OR and XOR, logical shifts in both directions, an arithmetic right shift, a bit-order reversal, a load of the low half-word that keeps the upper half, a plain move, and three multiplies. The multiplies return the low product word, the unsigned high word or the signed high word. There are also a compare and a bit test, which set flags but do not write a register.

Every other opcode is reported on `unsupported` and never requests a write. These include division, memory access, floating point and the special instructions. The surrounding pipeline uses `reg_wr` to decide whether the result is retired into the register file.

Top module: `int_exec_unit`

## Requirements
- R1: `out_valid` is high exactly one cycle after `in_valid` was high, and low otherwise. When `in_valid` is low, `result` and the four flags keep their previous values on the next cycle.
- R2: Opcode 00010 returns A+B, with C set to the carry out. Opcode 00000 returns A-B, with C set to the borrow (A < B unsigned). For both, V is set on signed overflow.
- R3: Opcode 00001 returns A AND B, opcode 00011 returns A OR B, and opcode 00100 returns A XOR B.
- R4: Opcode 00101 shifts A right logically, opcode 00110 shifts A left logically, and opcode 00111 shifts A right arithmetically. The shift amount is the full unsigned value of B. An amount of 32 or more gives 0 for the logical shifts and 32 copies of A[31] for the arithmetic shift.
- R5: For the shifts, C holds the last bit shifted out of A. It is 0 for an amount of 0 and for amounts above 32 on the logical shifts, and it is A[31] for amounts of 32 or more on the arithmetic shift.
- R6: Opcode 01000 returns B with its bit order reversed, so B[0] moves to result bit 31.
- R7: Opcode 01001 returns {A[31:16], B[15:0]}.
- R8: The multiplies use the 64-bit product of A and B. Opcode 01100 returns the low 32 bits. Opcode 01010 returns the high 32 bits with both operands treated as unsigned. Opcode 01011 returns the high 32 bits with both operands treated as two's complement.
- R9: Opcode 01101 returns B unchanged.
- R10: Opcode 10000 evaluates A-B and opcode 10001 evaluates A AND B, with the flags set as for SUB and AND. Neither asserts `reg_wr`. Every other supported opcode asserts `reg_wr`.
- R11: For supported opcodes, Z is set when the result is zero and N equals result bit 31. C and V are 0 for every opcode not named in R2, R4 and R5.
- R12: Opcodes 01110, 01111 and 10010 through 11111 raise `unsupported` with `out_valid`, keep `reg_wr` low, and give a result of 0 with all flags clear.
- R13: While reset is asserted, and until the first accepted operation, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released inside on the clock |
| in_valid | input | 1 | Operation strobe |
| op | input | 5 | Major opcode |
| opnd_a | input | 32 | Operand A |
| opnd_b | input | 32 | Operand B |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 32 | Operation result |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry, borrow or shifted-out bit |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Signed overflow flag |
| reg_wr | output | 1 | Result is to be written to the destination |
| unsupported | output | 1 | Opcode is not executed by this unit |

## Verification
Every output of this unit is due exactly one clock after the edge that captures `in_valid`, the opcode and the operands. This holds for result, flags, `reg_wr`, `unsupported` and `out_valid` alike. The bench drives each operation on a falling edge. At the next falling edge it compares all outputs with a behavioural model of the operation driven one step earlier. On idle cycles the model carries its previous values forward, so the hold behaviour is checked on the same schedule.

// File: rtl/exu_pkg.sv
`timescale 1ns/1ps
package exu_pkg;

  typedef enum logic [4:0] {
    OP_SUB   = 5'h00,
    OP_AND   = 5'h01,
    OP_ADD   = 5'h02,
    OP_OR    = 5'h03,
    OP_XOR   = 5'h04,
    OP_LSR   = 5'h05,
    OP_LSL   = 5'h06,
    OP_ASR   = 5'h07,
    OP_BREV  = 5'h08,
    OP_LDLO  = 5'h09,
    OP_MPYUH = 5'h0A,
    OP_MPYSH = 5'h0B,
    OP_MPY   = 5'h0C,
    OP_MOV   = 5'h0D,
    OP_CMP   = 5'h10,
    OP_TEST  = 5'h11
  } exu_op_e;

  typedef enum logic [1:0] {
    SH_LSR = 2'd0,
    SH_LSL = 2'd1,
    SH_ASR = 2'd2
  } exu_shift_e;

endpackage

// File: rtl/exu_addsub.sv
`timescale 1ns/1ps
module exu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  output logic [DATA_W-1:0] sum,
  output logic              carry,
  output logic              ovf
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] bx;
  logic              co;

  // subtraction is A + ~B + 1 on the same carry chain
  assign bx = sub ? ~b : b;
  assign {co, sum} = {1'b0, a} + {1'b0, bx} + {{DATA_W{1'b0}}, sub};
  // borrow is the inverse of the chain carry when subtracting
  assign carry = sub ? ~co : co;
  assign ovf   = (a[MSB] == bx[MSB]) && (sum[MSB] != a[MSB]);

endmodule

// File: rtl/exu_shifter.sv
`timescale 1ns/1ps
module exu_shifter
  import exu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] amt,
  input  exu_shift_e        kind,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  localparam int              SH_W  = $clog2(DATA_W);
  localparam int              MSB   = DATA_W - 1;
  localparam logic [DATA_W-1:0] W_VAL = DATA_W;

  logic [SH_W-1:0] sh;
  logic            over;
  logic            exact;
  logic [DATA_W:0] rt;
  logic [DATA_W:0] lt;

  assign sh    = amt[SH_W-1:0];
  assign over  = |amt[DATA_W-1:SH_W];
  assign exact = (amt == W_VAL);

  // one extra bit beside the operand catches the last bit shifted out
  always_comb begin
    rt   = '0;
    lt   = '0;
    res  = '0;
    cout = 1'b0;
    case (kind)
      SH_LSL: begin
        lt = {1'b0, a} << sh;
        if (over) begin
          res  = '0;
          cout = exact ? a[0] : 1'b0;
        end else begin
          res  = lt[DATA_W-1:0];
          cout = lt[DATA_W];
        end
      end
      SH_ASR: begin
        rt = $signed({a, 1'b0}) >>> sh;
        if (over) begin
          res  = {DATA_W{a[MSB]}};
          cout = a[MSB];
        end else begin
          res  = rt[DATA_W:1];
          cout = rt[0];
        end
      end
      default: begin
        rt = {a, 1'b0} >> sh;
        if (over) begin
          res  = '0;
          cout = exact ? a[MSB] : 1'b0;
        end else begin
          res  = rt[DATA_W:1];
          cout = rt[0];
        end
      end
    endcase
  end

endmodule

// File: rtl/exu_mult.sv
`timescale 1ns/1ps
module exu_mult #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] lo,
  output logic [DATA_W-1:0] hi_u,
  output logic [DATA_W-1:0] hi_s
);
  localparam int MSB = DATA_W - 1;

  logic [2*DATA_W-1:0] prod;

  assign prod = {{DATA_W{1'b0}}, a} * {{DATA_W{1'b0}}, b};
  assign lo   = prod[DATA_W-1:0];
  assign hi_u = prod[2*DATA_W-1:DATA_W];
  // signed high word corrected from the unsigned one: no second multiplier
  assign hi_s = hi_u - (a[MSB] ? b : '0) - (b[MSB] ? a : '0);

endmodule

// File: rtl/int_exec_unit.sv
`timescale 1ns/1ps
module int_exec_unit
  import exu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OP_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              flag_z,
  output logic              flag_c,
  output logic              flag_n,
  output logic              flag_v,
  output logic              reg_wr,
  output logic              unsupported
);
  localparam int MSB    = DATA_W - 1;
  localparam int HALF_W = DATA_W / 2;

  // reset: asserted at once, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  // datapath units
  exu_op_e           op_e;
  logic              sub_sel;
  logic [DATA_W-1:0] as_sum;
  logic              as_carry;
  logic              as_ovf;
  exu_shift_e        sh_kind;
  logic [DATA_W-1:0] sh_res;
  logic              sh_cout;
  logic [DATA_W-1:0] mul_lo;
  logic [DATA_W-1:0] mul_hi_u;
  logic [DATA_W-1:0] mul_hi_s;
  logic [DATA_W-1:0] rev_b;

  assign op_e    = exu_op_e'(op);
  assign sub_sel = (op_e == OP_SUB) || (op_e == OP_CMP);

  always_comb begin
    case (op_e)
      OP_LSL:  sh_kind = SH_LSL;
      OP_ASR:  sh_kind = SH_ASR;
      default: sh_kind = SH_LSR;
    endcase
  end

  exu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a(opnd_a), .b(opnd_b), .sub(sub_sel),
    .sum(as_sum), .carry(as_carry), .ovf(as_ovf)
  );

  exu_shifter #(.DATA_W(DATA_W)) u_shift (
    .a(opnd_a), .amt(opnd_b), .kind(sh_kind),
    .res(sh_res), .cout(sh_cout)
  );

  exu_mult #(.DATA_W(DATA_W)) u_mult (
    .a(opnd_a), .b(opnd_b),
    .lo(mul_lo), .hi_u(mul_hi_u), .hi_s(mul_hi_s)
  );

  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_rev
    assign rev_b[gi] = opnd_b[MSB-gi];
  end

  // next-state selection
  logic [DATA_W-1:0] nxt_res;
  logic              nxt_z;
  logic              nxt_c;
  logic              nxt_n;
  logic              nxt_v;
  logic              nxt_wr;
  logic              nxt_uns;

  always_comb begin
    nxt_res = '0;
    nxt_c   = 1'b0;
    nxt_v   = 1'b0;
    nxt_wr  = 1'b1;
    nxt_uns = 1'b0;
    case (op_e)
      OP_SUB, OP_ADD: begin
        nxt_res = as_sum;
        nxt_c   = as_carry;
        nxt_v   = as_ovf;
      end
      OP_CMP: begin
        nxt_res = as_sum;
        nxt_c   = as_carry;
        nxt_v   = as_ovf;
        nxt_wr  = 1'b0;
      end
      OP_AND:  nxt_res = opnd_a & opnd_b;
      OP_TEST: begin
        nxt_res = opnd_a & opnd_b;
        nxt_wr  = 1'b0;
      end
      OP_OR:   nxt_res = opnd_a | opnd_b;
      OP_XOR:  nxt_res = opnd_a ^ opnd_b;
      OP_LSR, OP_LSL, OP_ASR: begin
        nxt_res = sh_res;
        nxt_c   = sh_cout;
      end
      OP_BREV:  nxt_res = rev_b;
      OP_LDLO:  nxt_res = {opnd_a[DATA_W-1:HALF_W], opnd_b[HALF_W-1:0]};
      OP_MPYUH: nxt_res = mul_hi_u;
      OP_MPYSH: nxt_res = mul_hi_s;
      OP_MPY:   nxt_res = mul_lo;
      OP_MOV:   nxt_res = opnd_b;
      default: begin
        nxt_wr  = 1'b0;
        nxt_uns = 1'b1;
      end
    endcase
    nxt_z = !nxt_uns && (nxt_res == '0);
    nxt_n = !nxt_uns && nxt_res[MSB];
  end

  // registers: data held when idle, control qualified by the strobe
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      result <= '0;
      flag_z <= 1'b0;
      flag_c <= 1'b0;
      flag_n <= 1'b0;
      flag_v <= 1'b0;
    end else if (in_valid) begin
      result <= nxt_res;
      flag_z <= nxt_z;
      flag_c <= nxt_c;
      flag_n <= nxt_n;
      flag_v <= nxt_v;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      out_valid   <= 1'b0;
      reg_wr      <= 1'b0;
      unsupported <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      reg_wr      <= in_valid & nxt_wr;
      unsupported <= in_valid & nxt_uns;
    end
  end

endmodule

// File: rtl/exu_checker.sv
`timescale 1ns/1ps
module exu_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [4:0]        op,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              flag_z,
  input logic              flag_n,
  input logic              reg_wr,
  input logic              unsupported
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r1_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

  a_r10_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (op == 5'h10 || op == 5'h11) |=> !reg_wr && !unsupported);

  a_r11_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !unsupported |-> flag_z == (result == '0));

  a_r11_neg: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !unsupported |-> flag_n == result[DATA_W-1]);

  a_r12_raised: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (op == 5'h0E || op == 5'h0F || op >= 5'h12) |=> unsupported);

  a_r12_clean: assert property (@(posedge clk) disable iff (!rst_n)
    unsupported |-> out_valid && !reg_wr && result == '0 && !flag_z);

endmodule

bind int_exec_unit exu_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .in_valid(in_valid), .op(op),
  .out_valid(out_valid), .result(result), .flag_z(flag_z), .flag_n(flag_n),
  .reg_wr(reg_wr), .unsupported(unsupported)
);

// File: tb/int_exec_unit_bench.sv
`timescale 1ns/1ps
module int_exec_unit_bench;
  localparam time HALF = 10ns;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [4:0]  op;
  logic [31:0] opnd_a;
  logic [31:0] opnd_b;
  logic        out_valid;
  logic [31:0] result;
  logic        flag_z, flag_c, flag_n, flag_v, reg_wr, unsupported;

  int unsigned n_run;
  int unsigned n_fail;
  bit          done;

  // expected state
  logic        e_vld, e_z, e_c, e_n, e_v, e_wr, e_uns;
  logic [31:0] e_res;
  logic [4:0]  e_op;

  int_exec_unit u_int_exec_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid), .result(result),
    .flag_z(flag_z), .flag_c(flag_c), .flag_n(flag_n), .flag_v(flag_v),
    .reg_wr(reg_wr), .unsupported(unsupported)
  );

  initial clk = 1'b0;
  always #HALF clk = ~clk;

  function automatic string req_of(input logic [4:0] o);
    case (o)
      5'h00, 5'h02:        return "R2";
      5'h01, 5'h03, 5'h04: return "R3";
      5'h05, 5'h06, 5'h07: return "R4";
      5'h08:               return "R6";
      5'h09:               return "R7";
      5'h0A, 5'h0B, 5'h0C: return "R8";
      5'h0D:               return "R9";
      5'h10, 5'h11:        return "R10";
      default:             return "R12";
    endcase
  endfunction

  function automatic string c_req(input logic [4:0] o);
    if (o == 5'h00 || o == 5'h02 || o == 5'h10) return "R2";
    if (o >= 5'h05 && o <= 5'h07) return "R5";
    if (o == 5'h0E || o == 5'h0F || o >= 5'h12) return "R12";
    return "R11";
  endfunction

  task automatic check1(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h (op %h)", req, what, act, exp, e_op);
    end
  endtask

  // behavioural reference of one operation
  task automatic model(input logic [4:0] o, input logic [31:0] a, input logic [31:0] b,
                       output logic [31:0] r, output logic z, output logic c,
                       output logic n, output logic v, output logic wr, output logic uns);
    logic [32:0] wide;
    logic [63:0] pu;
    logic signed [63:0] ps;
    r = 0; c = 0; v = 0; wr = 1; uns = 0;
    case (o)
      5'h00, 5'h10: begin
        r = a - b; c = (a < b);
        v = (a[31] != b[31]) && (r[31] != a[31]);
        wr = (o == 5'h00);
      end
      5'h02: begin
        wide = {1'b0, a} + {1'b0, b}; r = wide[31:0]; c = wide[32];
        v = (a[31] == b[31]) && (r[31] != a[31]);
      end
      5'h01: r = a & b;
      5'h11: begin r = a & b; wr = 0; end
      5'h03: r = a | b;
      5'h04: r = a ^ b;
      5'h05: begin
        if (b >= 32) r = 0; else r = a >> b;
        c = (b >= 1 && b <= 32) ? a[int'(b) - 1] : 1'b0;
      end
      5'h06: begin
        if (b >= 32) r = 0; else r = a << b;
        c = (b >= 1 && b <= 32) ? a[32 - int'(b)] : 1'b0;
      end
      5'h07: begin
        if (b >= 32) begin r = {32{a[31]}}; c = a[31]; end
        else begin
          r = $signed(a) >>> b;
          c = (b == 0) ? 1'b0 : a[int'(b) - 1];
        end
      end
      5'h08: for (int i = 0; i < 32; i++) r[i] = b[31 - i];
      5'h09: r = {a[31:16], b[15:0]};
      5'h0A: begin pu = {32'd0, a} * {32'd0, b}; r = pu[63:32]; end
      5'h0B: begin
        ps = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
        r = ps[63:32];
      end
      5'h0C: begin pu = {32'd0, a} * {32'd0, b}; r = pu[31:0]; end
      5'h0D: r = b;
      default: begin wr = 0; uns = 1; end
    endcase
    z = !uns && (r == 0);
    n = !uns && r[31];
  endtask

  task automatic check_all();
    string rr;
    rr = e_vld ? req_of(e_op) : "R1";
    check1("R1", "out_valid", {31'd0, out_valid}, {31'd0, e_vld});
    check1(rr, "result", result, e_res);
    check1((e_uns && e_vld) ? "R12" : "R11", "flag_z", {31'd0, flag_z}, {31'd0, e_z});
    check1((e_uns && e_vld) ? "R12" : "R11", "flag_n", {31'd0, flag_n}, {31'd0, flag_n === 1'bx ? 1'b1 : e_n});
    check1(c_req(e_op), "flag_c", {31'd0, flag_c}, {31'd0, e_c});
    check1(c_req(e_op), "flag_v", {31'd0, flag_v}, {31'd0, e_v});
    check1((e_op == 5'h10 || e_op == 5'h11) ? "R10" : "R12", "reg_wr", {31'd0, reg_wr}, {31'd0, e_wr});
    check1("R12", "unsupported", {31'd0, unsupported}, {31'd0, e_uns});
  endtask

  // one cycle: check what the last edge produced, then drive the next operation
  task automatic step(input logic v, input logic [4:0] o, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r;
    logic z, c, n, vf, wr, uns;
    @(negedge clk);
    check_all();
    in_valid = v; op = o; opnd_a = a; opnd_b = b;
    if (v) begin
      model(o, a, b, r, z, c, n, vf, wr, uns);
      e_vld = 1; e_res = r; e_z = z; e_c = c; e_n = n; e_v = vf; e_wr = wr; e_uns = uns;
      e_op = o;
    end else begin
      e_vld = 0; e_wr = 0; e_uns = 0;
    end
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 0;
    in_valid = 0; op = 0; opnd_a = 0; opnd_b = 0;
    e_vld = 0; e_res = 0; e_z = 0; e_c = 0; e_n = 0; e_v = 0; e_wr = 0; e_uns = 0; e_op = 5'h1F;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R13: reset state
    check1("R13", "reset outputs",
           {19'd0, out_valid, flag_z, flag_c, flag_n, flag_v, reg_wr, unsupported, 6'd0} | result,
           32'd0);
    rst_n = 1;
    repeat (3) step(0, 0, 0, 0);

    // R2 add and subtract corners
    step(1, 5'h02, 32'h7fffffff, 32'h1);
    step(1, 5'h02, 32'hffffffff, 32'h1);
    step(1, 5'h00, 32'h0, 32'h1);
    step(1, 5'h00, 32'h80000000, 32'h1);
    step(1, 5'h00, 32'h5, 32'h5);
    // R10 compare and test
    step(1, 5'h10, 32'h1234, 32'h1234);
    step(1, 5'h10, 32'h1, 32'h2);
    step(1, 5'h11, 32'hf0f0, 32'h0f0f);
    // R3 logic
    step(1, 5'h01, 32'hff00ff00, 32'h0ff00ff0);
    step(1, 5'h03, 32'h80000000, 32'h1);
    step(1, 5'h04, 32'haaaa5555, 32'haaaa5555);
    // R4 / R5 shifts around the 32 boundary
    for (int k = 0; k < 6; k++) begin
      logic [31:0] amt;
      amt = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 31 : (k == 3) ? 32 : (k == 4) ? 33 : 32'h80000001;
      step(1, 5'h05, 32'h80000001, amt);
      step(1, 5'h06, 32'h80000001, amt);
      step(1, 5'h07, 32'h80000001, amt);
      step(1, 5'h07, 32'h40000001, amt);
    end
    // R6 R7 R8 R9
    step(1, 5'h08, 32'h0, 32'h1);
    step(1, 5'h08, 32'h0, 32'h12345678);
    step(1, 5'h09, 32'habcd1234, 32'h9999beef);
    step(1, 5'h0A, 32'hffffffff, 32'hffffffff);
    step(1, 5'h0B, 32'hffffffff, 32'hffffffff);
    step(1, 5'h0B, 32'hfffffffe, 32'h3);
    step(1, 5'h0C, 32'h10000, 32'h10000);
    step(1, 5'h0D, 32'hdeadbeef, 32'h80000000);
    // R12 unsupported codes, then an idle gap for R1 hold
    step(1, 5'h0E, 32'h1, 32'h1);
    step(1, 5'h0F, 32'h1, 32'h1);
    step(1, 5'h12, 32'h1, 32'h1);
    step(1, 5'h18, 32'h1, 32'h1);
    step(1, 5'h1F, 32'h1, 32'h1);
    step(1, 5'h02, 32'h80000000, 32'h80000000);
    step(0, 5'h00, 32'h5, 32'h6);
    step(0, 5'h1F, 32'h0, 32'h0);

    for (int i = 0; i < 1500; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = ($urandom % 2 == 0) ? ($urandom % 40) : $urandom;
      step(($urandom % 4) != 0, 5'($urandom % 32), ra, rb);
    end
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(2 * HALF * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule